// File: doc/BRIEF.md
# Quadrature NCO Complex Mixer

This block shifts a complex baseband stream in frequency. A 24-bit phase accumulator advances by a tuning word once for every accepted sample. The top bits of the accumulator, plus a 12-bit phase offset, address a quarter-wave sine table. Symmetry rebuilds a full sine and cosine from that table. These two values rotate each I/Q pair through a complex multiply, and the result is rounded back to the input width with saturation. The block runs at one quarter of the converter update rate and sits ahead of the interpolation chain, where it provides fine tuning. One tuning step is the sample rate divided by 2^24.

Frequency hops are double-buffered, so that a sample never mixes an old frequency with a new phase. A hop request that arrives together with a sample takes effect on that sample. A hop request that arrives on an idle cycle is captured and held, and it is applied to the next accepted sample. This hold is done by a two-state hop controller:
- `HOP_RUN` is the state with no pending update.
- `HOP_PEND` is the state in which an update is waiting.

The controller makes these transitions:
- RUN to PEND on a hop request without a sample.
- PEND to PEND on a further idle cycle. A fresh request on that cycle overwrites the held words.
- PEND to RUN on the next accepted sample.
- RUN to RUN otherwise.

A synchronous phase clear zeroes the accumulator, which makes a phase-coherent restart possible.

Top module: `quad_nco_mixer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_i` and `out_q` are 0, the accumulator is 0, and the active tuning and offset words are 0.
- R2: Each accepted sample (`in_valid` = 1) advances the 24-bit accumulator by the active tuning word, modulo 2^24. Cycles with `in_valid` = 0 leave the accumulator unchanged.
- R3: An accepted sample uses the phase index p, which is bits [23:14] of (accumulator + `poff_in`·2^12) taken before the advance. With θ = 2π(p+0.5)/1024, the outputs are `out_i` = I·cos θ − Q·sin θ and `out_q` = I·sin θ + Q·cos θ. Each is scaled by 32767/32768, and the result is accurate to within 112 LSB.
- R4: Each output is rounded to the nearest integer, half up, after dropping 15 fraction bits. It is then saturated to the range −32768..32767.
- R5: Latency is fixed at 3 clock cycles. `out_valid` pulses exactly once for each accepted sample, 3 cycles after it, and never at any other time.
- R6: When `hop_req` = 1 and `in_valid` = 1 in the same cycle, the presented `ftw_in` and `poff_in` become active. The offset applies to that same sample, and the new word drives the advance that follows it.
- R7: When `hop_req` = 1 and `in_valid` = 0, the presented words are held. They become active at the next accepted sample. A later idle-cycle request replaces the held words.
- R8: Changes on `ftw_in` or `poff_in` while `hop_req` = 0 have no effect on the output.
- R9: `phase_clr` = 1 sets the accumulator to 0 at the next clock edge. A sample accepted in the same cycle still uses the accumulator value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter of the converter update rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase input sample |
| in_q | input | 16 | Signed quadrature input sample |
| ftw_in | input | 24 | Requested frequency tuning word |
| poff_in | input | 12 | Requested phase offset word |
| hop_req | input | 1 | Update request that loads the tuning and offset words |
| phase_clr | input | 1 | Synchronous accumulator clear |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed shifted in-phase output |
| out_q | output | 16 | Signed shifted quadrature output |

## Verification
Directed samples come first:
- A real-only input at zero phase, then again at a quarter-turn offset. These cases separate the sine lane from the cosine lane and expose a swapped or mis-signed product term.
- Full-scale opposite-sign pairs near 45°. These drive both saturation rails and separate saturation from wrap-around.
- A tuning word of three quarters of a turn, which makes the accumulator wrap across all four quadrants.
- An idle-cycle hop followed by garbage on the word inputs. This separates held, pending and ignored words.
- A clear issued together with a sample. This shows which phase that sample uses.

A seeded random stream then mixes gaps, hops and clears with full-range I/Q. Every output is compared with a real-valued rotation and with its expected cycle.

// File: rtl/quad_nco_pkg.sv
package quad_nco_pkg;

    typedef enum logic [0:0] {
        HOP_RUN  = 1'b0,
        HOP_PEND = 1'b1
    } hop_state_e;

    // Quarter-wave entry k of a table with 2^qb entries, sampled at bin
    // midpoints. Rational sine approximation in integer arithmetic,
    // evaluated at elaboration only.
    function automatic longint quarter_sine(input int k, input int qb, input longint amp);
        longint h;
        longint x;
        longint xs;
        longint num;
        longint den;
        h   = longint'(1) <<< (qb + 2);
        x   = 2 * longint'(k) + 1;
        xs  = x * (h - x);
        num = amp * 16 * xs;
        den = 5 * h * h - 4 * xs;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
    import quad_nco_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACC_W = 24,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [ACC_W-1:0]     ftw_in,
    input  logic [OFF_W-1:0]     poff_in,
    input  logic                 hop_req,
    input  logic                 phase_clr,
    output logic                 ph_valid,
    output logic [IDX_W-1:0]     ph_idx,
    output logic signed [DW-1:0] ph_i,
    output logic signed [DW-1:0] ph_q
);
    localparam int DROP = OFF_W - IDX_W;

    hop_state_e       state_q, state_d;
    logic             apply_now;
    logic [ACC_W-1:0] ftw_act, ftw_shd, ftw_eff, acc_q;
    logic [OFF_W-1:0] poff_act, poff_shd, poff_eff, ph_hi;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= HOP_RUN;
        else     state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d   = state_q;
        apply_now = 1'b0;
        unique case (state_q)
            HOP_RUN: begin
                if (hop_req) begin
                    if (in_valid) apply_now = 1'b1;
                    else          state_d   = HOP_PEND;
                end
            end
            HOP_PEND: begin
                if (in_valid) begin
                    apply_now = 1'b1;
                    state_d   = HOP_RUN;
                end
            end
        endcase
    end

    // effective words for the sample in flight: newest request wins
    always_comb begin
        if (apply_now && hop_req) begin
            ftw_eff  = ftw_in;
            poff_eff = poff_in;
        end else if (apply_now) begin
            ftw_eff  = ftw_shd;
            poff_eff = poff_shd;
        end else begin
            ftw_eff  = ftw_act;
            poff_eff = poff_act;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_shd  <= '0;
            poff_shd <= '0;
            ftw_act  <= '0;
            poff_act <= '0;
        end else begin
            if (hop_req) begin
                ftw_shd  <= ftw_in;
                poff_shd <= poff_in;
            end
            if (apply_now) begin
                ftw_act  <= ftw_eff;
                poff_act <= poff_eff;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            acc_q <= '0;
        else if (phase_clr) acc_q <= '0;
        else if (in_valid)  acc_q <= acc_q + ftw_eff;
    end

    assign ph_hi = acc_q[ACC_W-1 -: OFF_W] + poff_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_valid <= 1'b0;
            ph_idx   <= '0;
            ph_i     <= '0;
            ph_q     <= '0;
        end else begin
            ph_valid <= in_valid;
            if (in_valid) begin
                ph_idx <= IDX_W'(ph_hi >> DROP);
                ph_i   <= in_i;
                ph_q   <= in_q;
            end
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> acc_q == '0) else $error("clear missed"); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !phase_clr) |=> $stable(acc_q)) else $error("idle advance"); // R2
    AST_HOP_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (hop_req && in_valid) |=> (ftw_act == $past(ftw_in) && poff_act == $past(poff_in)))
        else $error("hop not applied"); // R6
    AST_PEND_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == HOP_PEND && in_valid) |=> state_q == HOP_RUN) else $error("pend stuck"); // R7
    AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!hop_req && state_q == HOP_RUN) |=> ($stable(ftw_act) && $stable(poff_act)))
        else $error("words moved"); // R8

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
    import quad_nco_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idx_valid,
    input  logic [IDX_W-1:0]     idx,
    output logic                 lut_valid,
    output logic signed [DW-1:0] sin_o,
    output logic signed [DW-1:0] cos_o
);
    localparam int     QB  = IDX_W - 2;
    localparam int     NQ  = 1 << QB;
    localparam longint AMP = (longint'(1) <<< (DW - 1)) - 1;

    logic [DW-2:0]            qrom [NQ];
    logic [1:0][DW-1:0]       lane_d;

    for (genvar k = 0; k < NQ; k++) begin : g_tab
        assign qrom[k] = (DW-1)'(quarter_sine(k, QB, AMP));
    end

    // lane 0: sine, lane 1: cosine (quadrant advanced by one)
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [1:0]    quad;
        logic [QB-1:0] addr;
        logic [DW-2:0] mag;
        assign quad = idx[IDX_W-1 -: 2] + 2'(g);
        assign addr = quad[0] ? ~idx[QB-1:0] : idx[QB-1:0];
        assign mag  = qrom[addr];
        assign lane_d[g] = quad[1] ? -{1'b0, mag} : {1'b0, mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_valid <= 1'b0;
            sin_o     <= '0;
            cos_o     <= '0;
        end else begin
            lut_valid <= idx_valid;
            if (idx_valid) begin
                sin_o <= $signed(lane_d[0]);
                cos_o <= $signed(lane_d[1]);
            end
        end
    end

    AST_FIRST_QUADRANT: assert property (@(posedge clk) disable iff (rst)
        (idx_valid && idx[IDX_W-1 -: 2] == 2'd0) |=> (sin_o > 0 && cos_o > 0))
        else $error("quadrant sign"); // R3

endmodule

// File: rtl/nco_cmul.sv
module nco_cmul #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] a_q,
    input  logic signed [DW-1:0] c,
    input  logic signed [DW-1:0] s,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int PW = 2 * DW + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - 1;
    localparam logic signed [PW-1:0] HALF = PW'(longint'(1) <<< (DW - 2));

    logic signed [2*DW-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [PW-1:0]   re_sum, im_sum;
    logic signed [DW-1:0]   re_sat, im_sat;

    assign p_ic = a_i * c;
    assign p_qs = a_q * s;
    assign p_is = a_i * s;
    assign p_qc = a_q * c;
    assign re_sum = {p_ic[2*DW-1], p_ic} - {p_qs[2*DW-1], p_qs};
    assign im_sum = {p_is[2*DW-1], p_is} + {p_qc[2*DW-1], p_qc};

    function automatic logic signed [DW-1:0] round_sat(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] sh;
        sh = (v + HALF) >>> (DW - 1);
        if (sh > MAXV)      return MAXV[DW-1:0];
        else if (sh < MINV) return MINV[DW-1:0];
        else                return sh[DW-1:0];
    endfunction

    assign re_sat = round_sat(re_sum);
    assign im_sat = round_sat(im_sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= re_sat;
                out_q <= im_sat;
            end
        end
    end

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_i == '0 && a_q == '0) |=> (out_i == '0 && out_q == '0))
        else $error("zero input leak"); // R4

endmodule

// File: rtl/quad_nco_mixer.sv
module quad_nco_mixer #(
    parameter int DW    = 16,
    parameter int ACC_W = 24,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [ACC_W-1:0]     ftw_in,
    input  logic [OFF_W-1:0]     poff_in,
    input  logic                 hop_req,
    input  logic                 phase_clr,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    logic                 ph_valid, lut_valid;
    logic [IDX_W-1:0]     ph_idx;
    logic signed [DW-1:0] ph_i, ph_q, lut_i, lut_q, sin_v, cos_v;

    nco_phase_gen #(.DW(DW), .ACC_W(ACC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .ftw_in    (ftw_in),
        .poff_in   (poff_in),
        .hop_req   (hop_req),
        .phase_clr (phase_clr),
        .ph_valid  (ph_valid),
        .ph_idx    (ph_idx),
        .ph_i      (ph_i),
        .ph_q      (ph_q)
    );

    nco_sincos_lut #(.DW(DW), .IDX_W(IDX_W)) u_lut (
        .clk       (clk),
        .rst       (rst),
        .idx_valid (ph_valid),
        .idx       (ph_idx),
        .lut_valid (lut_valid),
        .sin_o     (sin_v),
        .cos_o     (cos_v)
    );

    // keep samples aligned with the table stage
    always_ff @(posedge clk) begin
        if (rst) begin
            lut_i <= '0;
            lut_q <= '0;
        end else if (ph_valid) begin
            lut_i <= ph_i;
            lut_q <= ph_q;
        end
    end

    nco_cmul #(.DW(DW)) u_cmul (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lut_valid),
        .a_i       (lut_i),
        .a_q       (lut_q),
        .c         (cos_v),
        .s         (sin_v),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    AST_VALID_STAGE2: assert property (@(posedge clk) disable iff (rst)
        ph_valid |=> lut_valid) else $error("valid dropped"); // R5
    AST_NO_SPURIOUS_STAGE2: assert property (@(posedge clk) disable iff (rst)
        !ph_valid |=> !lut_valid) else $error("valid invented"); // R5
    AST_VALID_STAGE3: assert property (@(posedge clk) disable iff (rst)
        lut_valid |=> out_valid) else $error("valid dropped"); // R5
    AST_NO_SPURIOUS_STAGE3: assert property (@(posedge clk) disable iff (rst)
        !lut_valid |=> !out_valid) else $error("valid invented"); // R5

endmodule

// File: tb/quad_nco_mixer_test.sv
`timescale 1ns/1ps
module quad_nco_mixer_test;
    localparam real PI  = 3.14159265358979323846;
    localparam real TOL = 112.0;
    localparam int  MAXS = 4096;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [23:0]        ftw_in = '0;
    logic [11:0]        poff_in = '0;
    logic               hop_req = 1'b0, phase_clr = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    quad_nco_mixer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .ftw_in(ftw_in), .poff_in(poff_in), .hop_req(hop_req), .phase_clr(phase_clr),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    int    n_checks = 0, n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    int    n_exp = 0, n_out = 0;
    real   exp_ri [MAXS];
    real   exp_rq [MAXS];
    int    exp_cy [MAXS];
    string exp_tag [MAXS];

    // reference model state
    logic [23:0] m_acc = '0, m_ftw = '0, m_sftw = '0;
    logic [11:0] m_poff = '0, m_spoff = '0;
    bit          m_pend = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real clampr(input real v);
        if (v > 32767.0)  return 32767.0;
        if (v < -32768.0) return -32768.0;
        return v;
    endfunction

    task automatic check_val(input string tag, input string what, input int got, input real expv);
        real d;
        n_checks++;
        d = real'(got) - expv;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, $rtoi(expv));
        end
    endtask

    task automatic check_int(input string tag, input string what, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (n_out >= n_exp) begin
                check_int("R5", "unexpected out_valid count", n_out + 1, n_exp);
            end else begin
                check_int("R5", "output cycle", cyc, exp_cy[n_out]);
                check_val(exp_tag[n_out], "out_i", int'(out_i), exp_ri[n_out]);
                check_val(exp_tag[n_out], "out_q", int'(out_q), exp_rq[n_out]);
            end
            n_out++;
        end
    end

    task automatic drive(input bit v, input logic signed [15:0] i, input logic signed [15:0] q,
                         input bit hop, input logic [23:0] f, input logic [11:0] p,
                         input bit clr, input string tag);
        logic [23:0] ph;
        int          idx;
        real         ang, re, im;
        @(negedge clk);
        in_valid = v; in_i = i; in_q = q; hop_req = hop;
        ftw_in = f; poff_in = p; phase_clr = clr;
        if (v) begin
            if (hop) begin m_ftw = f; m_poff = p; m_pend = 0; end
            else if (m_pend) begin m_ftw = m_sftw; m_poff = m_spoff; m_pend = 0; end
            ph  = m_acc + {m_poff, 12'b0};
            idx = int'(ph[23:14]);
            ang = 2.0 * PI * (real'(idx) + 0.5) / 1024.0;
            re  = (real'(i) * $cos(ang) - real'(q) * $sin(ang)) * 32767.0 / 32768.0;
            im  = (real'(i) * $sin(ang) + real'(q) * $cos(ang)) * 32767.0 / 32768.0;
            if (n_exp < MAXS) begin
                exp_ri[n_exp]  = clampr(re);
                exp_rq[n_exp]  = clampr(im);
                exp_cy[n_exp]  = cyc + 3;
                exp_tag[n_exp] = tag;
                n_exp++;
            end
            m_acc = clr ? 24'd0 : m_acc + m_ftw;
        end else begin
            if (hop) begin m_sftw = f; m_spoff = p; m_pend = 1; end
            if (clr) m_acc = '0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 24'h0, 12'h0, 0, "idle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_int("R1", "out_valid", int'(out_valid), 0);
        check_int("R1", "out_i", int'(out_i), 0);
        check_int("R1", "out_q", int'(out_q), 0);

        // R3: zero phase, real input, then quarter turn offset
        drive(1, 16'sd20000, 16'sd0, 1, 24'h0, 12'h000, 1, "R3 zero phase");
        drive(1, 16'sd20000, 16'sd0, 1, 24'h0, 12'd1024, 0, "R3 quarter offset");
        drive(1, 16'sd0, 16'sd15000, 0, 24'h0, 12'h0, 0, "R3 imag input");
        drive(1, -16'sd12000, 16'sd9000, 1, 24'h0, 12'd2048, 0, "R3 half turn");
        idle(2);

        // R4: saturation at both rails near 45 degrees
        drive(1, 16'sd32767, -16'sd32767, 1, 24'h0, 12'd508, 0, "R4 positive rail");
        drive(1, -16'sd32768, 16'sd32767, 0, 24'h0, 12'h0, 0, "R4 negative rail");
        drive(1, 16'sd1, 16'sd0, 0, 24'h0, 12'h0, 0, "R4 tiny input");

        // R2: wrap across quadrants with gaps in between
        drive(0, 0, 0, 1, 24'hC00000, 12'h0, 1, "R2 setup");
        drive(1, 16'sd25000, 16'sd0, 0, 24'h0, 12'h0, 0, "R2 wrap step0");
        idle(3);
        drive(1, 16'sd25000, 16'sd0, 0, 24'h0, 12'h0, 0, "R2 wrap step1");
        drive(1, 16'sd25000, 16'sd0, 0, 24'h0, 12'h0, 0, "R2 wrap step2");
        drive(1, 16'sd25000, 16'sd0, 0, 24'h0, 12'h0, 0, "R2 wrap step3");

        // R7 and R8: idle hop held, word inputs toggled without request
        drive(0, 0, 0, 1, 24'h123456, 12'd700, 0, "R7 hold");
        drive(0, 0, 0, 0, 24'hFFFFFF, 12'hFFF, 0, "R8 ignore");
        drive(0, 0, 0, 1, 24'h040000, 12'd300, 0, "R7 replace");
        drive(0, 0, 0, 0, 24'h800000, 12'h800, 0, "R8 ignore");
        drive(1, 16'sd18000, 16'sd7000, 0, 24'hABCDEF, 12'h321, 0, "R7 applied");
        drive(1, 16'sd18000, 16'sd7000, 0, 24'h000001, 12'h001, 0, "R8 no effect");
        drive(1, 16'sd18000, 16'sd7000, 0, 24'h7FFFFF, 12'h7FF, 0, "R8 no effect");

        // R6 and R9: hop with sample, clear with and without sample
        drive(1, 16'sd22000, -16'sd5000, 1, 24'h100000, 12'd512, 0, "R6 hop on sample");
        drive(1, 16'sd22000, -16'sd5000, 0, 24'h0, 12'h0, 1, "R9 clear same cycle");
        drive(1, 16'sd22000, -16'sd5000, 0, 24'h0, 12'h0, 0, "R9 after clear");
        drive(0, 0, 0, 0, 24'h0, 12'h0, 1, "R9 idle clear");
        drive(1, 16'sd22000, -16'sd5000, 0, 24'h0, 12'h0, 0, "R9 after idle clear");

        // random stream
        for (int n = 0; n < 700; n++) begin
            bit v, h, c;
            v = ($urandom() % 100) < 70;
            h = ($urandom() % 100) < 6;
            c = ($urandom() % 100) < 2;
            drive(v, $signed(16'($urandom())), $signed(16'($urandom())), h,
                  24'($urandom()), 12'($urandom()), c, "R3 R6 R7 R8 random");
        end

        idle(6);
        check_int("R5", "outputs seen vs samples sent", n_out, n_exp);
        finish_run();
    end
endmodule